// File: doc/BRIEF.md
# Banked Register Command Decoder on a Serial Slave Link

This block is the serial front end of a small network controller. A host selects it by pulling chip select low and shifts in a one-byte command. The command either moves a single byte to or from a control register, merges a mask into a register by OR or AND-NOT, streams bytes to or from packet buffer memory, or resets the control state. Control registers are reached with a 5-bit address. Most of that space is split into four banks. The host picks the active bank through two bits of a control register that, like a few other registers, is present in every bank.

The decoder owns the registers shared by all banks and the two buffer pointers. The rest of the banked register space sits outside the block, behind a simple register port with a combinational read. Buffer memory hangs on a byte-wide port with a combinational read. Every buffer byte moved advances the matching pointer by one and wraps at the top of the pointer range. The serial pins are sampled by the system clock through a synchronizer, so the serial clock must run several times slower than the system clock.

Top module: `spi_bank_decoder`

## Requirements
- R1: The command byte holds an opcode in bits 7:5 and a register address in bits 4:0. Opcode 000 reads a register, 010 writes one, 100 sets bits and 101 clears bits. The whole bytes 0x3A, 0x7A and 0xFF mean buffer read, buffer write and soft reset. Any other command is ignored: no register, pointer or external write happens, and the reply bytes are 0x00.
- R2: The link uses mode 0 (sample on the rising serial clock, shift on the falling one) with the MSB first. The first reply bit is on `miso` before the first rising edge of the byte that follows the command.
- R3: Addresses 0x1B to 0x1F reach the same internal registers in every bank and never drive the external register port. These are interrupt enable at 0x1B, interrupt flags at 0x1C, status at 0x1D, control 2 at 0x1E and control 1 at 0x1F.
- R4: For addresses 0x00 to 0x1A, control 1 bits 1:0 give the bank, and the external port sees `regAddr` = {bank, address}. Bank-0 addresses 0x00 to 0x03 are excepted (see R7).
- R5: Slow-class registers are bank 2 addresses 0x00 to 0x1A, and bank 3 addresses 0x00 to 0x05 and 0x0A. A read of one of them returns a dummy byte 0x00 first and then the data. Every other read returns the data in the first byte after the command.
- R6: Bit set writes old OR mask, and bit clear writes old AND NOT mask, where the mask is the byte after the command. On slow-class registers both operations leave the register unchanged.
- R7: In bank 0, addresses 0x00/0x01 hold the read pointer (low byte, then the high bits) and 0x02/0x03 hold the write pointer. Command 0x7A stores each following byte at the write pointer and then increments the pointer, wrapping to 0, for as long as chip select stays low.
- R8: Command 0x3A returns the byte at the read pointer, then the following bytes in order. After N bytes have been clocked out, the read pointer has advanced by exactly N.
- R9: Status bit 0 reads 1 once reset has completed. The other status bits read 0. Writes and bit operations on status are ignored.
- R10: Chip select going high drops any partial byte. The next selection starts again with a fresh command byte.
- R11: Command 0xFF clears control 1 (so the bank becomes 0), the other shared registers and both pointers. It also pulses `softReset` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| regAddr | output | 7 | External register address {bank, address} |
| regWe | output | 1 | External register write strobe |
| regWdata | output | 8 | External register write data |
| regRdata | input | 8 | External register read data (combinational) |
| bufAddr | output | PTR_W | Buffer memory address |
| bufWe | output | 1 | Buffer memory write strobe |
| bufWdata | output | 8 | Buffer memory write data |
| bufRdata | input | 8 | Buffer memory read data (combinational) |
| softReset | output | 1 | One-cycle pulse on a soft-reset command |

## Verification
The bench targets the slow-class boundary in bank 3, where addresses 0x05 and 0x0A need the dummy byte and 0x07 does not. A design that got this wrong would hand the host data one byte early or one byte late. It also runs a mask operation against a slow-class register, which a careless design would corrupt, and lets the write pointer wrap from the top address back to 0, which would send bytes past the memory. Two more checks cover a chip select that rises mid-byte, which would leave the next command shifted by a few bits, and a buffer read whose pointer must not count the byte that is prefetched but never clocked out.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  typedef enum logic [2:0] {
    ST_CMD, ST_RDUMMY, ST_CWR, ST_BSET, ST_BCLR, ST_BRD, ST_BWR, ST_HOLD
  } dec_state_t;

  // strobes from control to datapath; data is the byte just received
  typedef struct packed {
    logic       regWr;
    logic       bitSet;
    logic       bitClr;
    logic       bufWr;
    logic       bufAdv;
    logic       softRst;
    logic [7:0] data;
  } dp_strobe_t;

  localparam logic [2:0] OP_CREAD  = 3'b000;
  localparam logic [2:0] OP_CWRITE = 3'b010;
  localparam logic [2:0] OP_BSET   = 3'b100;
  localparam logic [2:0] OP_BCLR   = 3'b101;

  localparam logic [7:0] CMD_BUF_RD   = 8'h3A;
  localparam logic [7:0] CMD_BUF_WR   = 8'h7A;
  localparam logic [7:0] CMD_SOFT_RST = 8'hFF;

  localparam logic [4:0] ADR_INTEN  = 5'h1B;
  localparam logic [4:0] ADR_INTFLG = 5'h1C;
  localparam logic [4:0] ADR_STATUS = 5'h1D;
  localparam logic [4:0] ADR_CTRL2  = 5'h1E;
  localparam logic [4:0] ADR_CTRL1  = 5'h1F;
  localparam logic [4:0] SHARED_BASE = ADR_INTEN;

  // registers that answer one byte late
  function automatic logic isSlowClass(input logic [1:0] bank, input logic [4:0] addr);
    if (addr >= SHARED_BASE) return 1'b0;
    if (bank == 2'd2) return 1'b1;
    if (bank == 2'd3) return (addr <= 5'h05) || (addr == 5'h0A);
    return 1'b0;
  endfunction

endpackage

// File: rtl/spi_bank_ctl.sv
module spi_bank_ctl
  import spi_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  input  logic [1:0] bank,
  input  logic [7:0] regVal,
  input  logic [7:0] bufRdata,
  output logic [4:0] lookAddr,
  output logic       inBufRead,
  output dp_strobe_t stb
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic       sclkPrev;
  logic       rise, fall, csHigh, mosiS, byteDone, slow;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] rxByte, txShift, txVal;
  logic       misoReg, txLd;
  logic [4:0] savedAddr;
  dec_state_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkPipe[TOP];
    end
  end

  assign csHigh   = csPipe[TOP];
  assign mosiS    = mosiPipe[TOP];
  assign rise     = sclkPipe[TOP] & ~sclkPrev;
  assign fall     = ~sclkPipe[TOP] & sclkPrev;
  assign rxByte   = {rxShift, mosiS};
  assign byteDone = rise & ~csHigh & (bitCnt == 3'd7);
  assign lookAddr = (state == ST_CMD) ? rxByte[4:0] : savedAddr;
  assign slow     = isSlowClass(bank, lookAddr);
  assign inBufRead = (state == ST_BRD);
  assign miso     = misoReg;

  always_comb begin
    stb      = '0;
    stb.data = rxByte;
    nxt      = state;
    txLd     = 1'b0;
    txVal    = 8'h00;
    if (byteDone) begin
      unique case (state)
        ST_CMD: begin
          txLd = 1'b1;
          nxt  = ST_HOLD;
          if (rxByte == CMD_SOFT_RST) stb.softRst = 1'b1;
          else if (rxByte == CMD_BUF_RD) begin
            nxt   = ST_BRD;
            txVal = bufRdata;
          end else if (rxByte == CMD_BUF_WR) nxt = ST_BWR;
          else begin
            case (rxByte[7:5])
              OP_CREAD:  if (slow) nxt = ST_RDUMMY; else txVal = regVal;
              OP_CWRITE: nxt = ST_CWR;
              OP_BSET:   nxt = ST_BSET;
              OP_BCLR:   nxt = ST_BCLR;
              default:   ;
            endcase
          end
        end
        ST_RDUMMY: begin txLd = 1'b1; txVal = regVal; nxt = ST_HOLD; end
        ST_CWR:    begin stb.regWr = 1'b1; nxt = ST_HOLD; end
        ST_BSET:   begin stb.bitSet = ~slow; nxt = ST_HOLD; end
        ST_BCLR:   begin stb.bitClr = ~slow; nxt = ST_HOLD; end
        ST_BRD:    begin stb.bufAdv = 1'b1; txLd = 1'b1; txVal = bufRdata; end
        ST_BWR:    stb.bufWr = 1'b1;
        default:   txLd = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_CMD;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      misoReg   <= 1'b0;
      savedAddr <= '0;
    end else if (csHigh) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      txShift <= '0;
      misoReg <= 1'b0;
    end else begin
      if (rise) begin
        bitCnt  <= bitCnt + 3'd1;
        rxShift <= rxByte[6:0];
      end
      if (byteDone) begin
        state <= nxt;
        if (state == ST_CMD) savedAddr <= rxByte[4:0];
      end
      if (txLd) txShift <= txVal;
      else if (fall) begin
        misoReg <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  // R10
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCnt == 3'd0 && state == ST_CMD));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.regWr, stb.bitSet, stb.bitClr, stb.bufWr, stb.bufAdv, stb.softRst}));

  // R2
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fall && !csHigh) |=> $stable(misoReg));

  // R6
  slow_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bitSet || stb.bitClr) |-> !isSlowClass(bank, lookAddr));

endmodule

// File: rtl/spi_bank_dp.sv
module spi_bank_dp
  import spi_bank_pkg::*;
#(
  parameter int PTR_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       stb,
  input  logic [4:0]       lookAddr,
  input  logic             inBufRead,
  output logic [1:0]       bank,
  output logic [7:0]       regVal,
  output logic [6:0]       regAddr,
  output logic             regWe,
  output logic [7:0]       regWdata,
  input  logic [7:0]       regRdata,
  output logic [PTR_W-1:0] bufAddr,
  output logic             bufWe,
  output logic [7:0]       bufWdata,
  output logic             softReset
);

  localparam int HI_W = PTR_W - 8;

  logic [7:0]       intEn, intFlg, ctrl2, ctrl1, newVal;
  logic             clkReady, isShared, isPtr, doWr;
  logic [PTR_W-1:0] rdPtr, wrPtr;

  assign bank     = ctrl1[1:0];
  assign isShared = (lookAddr >= SHARED_BASE);
  assign isPtr    = (bank == 2'd0) && (lookAddr <= 5'h03);
  assign doWr     = stb.regWr | stb.bitSet | stb.bitClr;

  always_comb begin
    if (isShared) begin
      case (lookAddr)
        ADR_INTEN:  regVal = intEn;
        ADR_INTFLG: regVal = intFlg;
        ADR_STATUS: regVal = {7'd0, clkReady};
        ADR_CTRL2:  regVal = ctrl2;
        default:    regVal = ctrl1;
      endcase
    end else if (isPtr) begin
      case (lookAddr[1:0])
        2'd0:    regVal = rdPtr[7:0];
        2'd1:    regVal = 8'(rdPtr >> 8);
        2'd2:    regVal = wrPtr[7:0];
        default: regVal = 8'(wrPtr >> 8);
      endcase
    end else regVal = regRdata;
  end

  always_comb begin
    if (stb.regWr)       newVal = stb.data;
    else if (stb.bitSet) newVal = regVal | stb.data;
    else                 newVal = regVal & ~stb.data;
  end

  assign regAddr   = {bank, lookAddr};
  assign regWe     = doWr & ~isShared & ~isPtr;
  assign regWdata  = newVal;
  assign bufWe     = stb.bufWr;
  assign bufWdata  = stb.data;
  assign bufAddr   = stb.bufWr ? wrPtr : (inBufRead ? rdPtr + PTR_W'(1) : rdPtr);
  assign softReset = stb.softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= '0; intFlg <= '0; ctrl2 <= '0; ctrl1 <= '0;
      rdPtr <= '0; wrPtr <= '0; clkReady <= 1'b0;
    end else begin
      clkReady <= 1'b1;
      if (stb.softRst) begin
        intEn <= '0; intFlg <= '0; ctrl2 <= '0; ctrl1 <= '0;
        rdPtr <= '0; wrPtr <= '0;
      end else if (doWr && isShared) begin
        case (lookAddr)
          ADR_INTEN:  intEn  <= newVal;
          ADR_INTFLG: intFlg <= newVal;
          ADR_CTRL2:  ctrl2  <= newVal;
          ADR_CTRL1:  ctrl1  <= newVal;
          default:    ;
        endcase
      end else if (doWr && isPtr) begin
        case (lookAddr[1:0])
          2'd0:    rdPtr[7:0]       <= newVal;
          2'd1:    rdPtr[PTR_W-1:8] <= newVal[HI_W-1:0];
          2'd2:    wrPtr[7:0]       <= newVal;
          default: wrPtr[PTR_W-1:8] <= newVal[HI_W-1:0];
        endcase
      end else if (stb.bufWr) wrPtr <= wrPtr + PTR_W'(1);
      else if (stb.bufAdv)    rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (bank == 2'd0 && rdPtr == '0 && wrPtr == '0));

  // R7
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWr |=> (wrPtr == PTR_W'($past(wrPtr) + 1'b1)));

  // R8
  rd_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufAdv |=> (rdPtr == PTR_W'($past(rdPtr) + 1'b1)));

  // R9
  clk_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkReady |=> clkReady);

  // R3
  shared_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regAddr[4:0] < SHARED_BASE));

  // R6
  mask_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bitSet && regWe) |-> ((regWdata & stb.data) == stb.data));

endmodule

// File: rtl/spi_bank_decoder.sv
module spi_bank_decoder
  import spi_bank_pkg::*;
#(
  parameter int PTR_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             mosi,
  output logic             miso,
  output logic [6:0]       regAddr,
  output logic             regWe,
  output logic [7:0]       regWdata,
  input  logic [7:0]       regRdata,
  output logic [PTR_W-1:0] bufAddr,
  output logic             bufWe,
  output logic [7:0]       bufWdata,
  input  logic [7:0]       bufRdata,
  output logic             softReset
);

  dp_strobe_t stb;
  logic [1:0] bank;
  logic [7:0] regVal;
  logic [4:0] lookAddr;
  logic       inBufRead;

  spi_bank_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .bank(bank), .regVal(regVal), .bufRdata(bufRdata),
    .lookAddr(lookAddr), .inBufRead(inBufRead), .stb(stb)
  );

  spi_bank_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lookAddr(lookAddr), .inBufRead(inBufRead),
    .bank(bank), .regVal(regVal), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .bufAddr(bufAddr), .bufWe(bufWe),
    .bufWdata(bufWdata), .softReset(softReset)
  );

endmodule

// File: tb/spi_bank_decoder_test.sv
module spi_bank_decoder_test;

  localparam int PTR_W = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, regWe, bufWe, softReset;
  logic [6:0] regAddr;
  logic [7:0] regWdata, regRdata, bufWdata, bufRdata;
  logic [PTR_W-1:0] bufAddr;

  logic [7:0] ext [128];
  logic [7:0] mem [1 << PTR_W];
  logic [7:0] expReg [128];
  int checks = 0, failures = 0, softCount = 0, weCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_bank_decoder #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .bufAddr(bufAddr), .bufWe(bufWe), .bufWdata(bufWdata), .bufRdata(bufRdata),
    .softReset(softReset)
  );

  assign regRdata = ext[regAddr];
  assign bufRdata = mem[bufAddr];

  always @(posedge clk) begin
    if (regWe) begin ext[regAddr] <= regWdata; weCount <= weCount + 1; end
    if (bufWe) mem[bufAddr] <= bufWdata;
    if (softReset) softCount <= softCount + 1;
  end

  function automatic bit slowReg(input int b, input int a);
    if (a >= 27) return 0;
    if (b == 2) return 1;
    if (b == 3 && (a <= 5 || a == 10)) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    spiBits(tx, 8, rx);
  endtask

  task automatic csOn;
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csOff;
    repeat (HALF) @(negedge clk); csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    csOn; spiByte(c, r); spiByte(d, r); csOff;
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    cmd2({3'b010, a}, d);
  endtask

  task automatic rdReg(input logic [4:0] a, input bit slow, output logic [7:0] v);
    logic [7:0] r;
    csOn; spiByte({3'b000, a}, r);
    if (slow) spiByte(8'h00, r);
    spiByte(8'h00, v); csOff;
  endtask

  task automatic setBank(input int b);
    wrReg(5'h1F, 8'(b));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, r, d, dm;
    logic [7:0] sent [6];
    int we0;
    for (int i = 0; i < 128; i++) begin ext[i] = 8'h00; expReg[i] = 8'h00; end
    for (int i = 0; i < (1 << PTR_W); i++) mem[i] = 8'(i * 7 + 3);
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R11 reset outputs", {miso, regWe, bufWe, softReset}, 4'b0);
    rdReg(5'h1D, 0, v); chk("R9 status after reset", v, 8'h01);
    rdReg(5'h1F, 0, v); chk("R4 control 1 after reset", v, 8'h00);

    // R9 status ignores writes and masks
    wrReg(5'h1D, 8'hF0);
    cmd2(8'h9D, 8'hFE);
    rdReg(5'h1D, 0, v); chk("R9 status write ignored", v, 8'h01);

    // R3 shared registers
    wrReg(5'h1B, 8'h5A);
    setBank(3);
    rdReg(5'h1B, 0, v); chk("R3 shared enable seen in bank 3", v, 8'h5A);
    rdReg(5'h1F, 0, v); chk("R3 control 1 in bank 3", v, 8'h03);
    chk("R3 no external write for shared", ext[{2'd3, 5'h1B}], 8'h00);

    // R4 banked external access, R2 first-byte data
    setBank(1);
    wrReg(5'h05, 8'hA5);
    chk("R4 external address", ext[{2'd1, 5'h05}], 8'hA5);
    rdReg(5'h05, 0, v); chk("R2 data in first byte", v, 8'hA5);

    // R5 slow class
    setBank(2);
    wrReg(5'h04, 8'h3C);
    csOn; spiByte(8'h04, r); spiByte(8'h00, dm); spiByte(8'h00, v); csOff;
    chk("R5 dummy byte value", dm, 8'h00);
    chk("R5 data after dummy", v, 8'h3C);
    setBank(3);
    wrReg(5'h05, 8'h81); wrReg(5'h0A, 8'h42); wrReg(5'h07, 8'h99);
    rdReg(5'h05, 1, v); chk("R5 bank3 0x05 slow", v, 8'h81);
    rdReg(5'h0A, 1, v); chk("R5 bank3 0x0A slow", v, 8'h42);
    rdReg(5'h07, 0, v); chk("R5 bank3 0x07 fast", v, 8'h99);

    // R6 masks
    setBank(1);
    wrReg(5'h06, 8'h0F);
    cmd2({3'b100, 5'h06}, 8'hF0);
    rdReg(5'h06, 0, v); chk("R6 bit set", v, 8'hFF);
    cmd2({3'b101, 5'h06}, 8'h3C);
    rdReg(5'h06, 0, v); chk("R6 bit clear", v, 8'hC3);
    setBank(2);
    wrReg(5'h03, 8'h11);
    cmd2({3'b100, 5'h03}, 8'hEE);
    cmd2({3'b101, 5'h03}, 8'h01);
    rdReg(5'h03, 1, v); chk("R6 slow class untouched", v, 8'h11);

    // R7 buffer write
    setBank(0);
    wrReg(5'h02, 8'h20); wrReg(5'h03, 8'h01);
    csOn; spiByte(8'h7A, r);
    for (int i = 0; i < 6; i++) begin sent[i] = 8'($urandom); spiByte(sent[i], r); end
    csOff;
    for (int i = 0; i < 6; i++) chk("R7 buffer byte stored", mem[10'h120 + i], sent[i]);
    rdReg(5'h02, 0, v); chk("R7 write pointer low", v, 8'h26);
    rdReg(5'h03, 0, v); chk("R7 write pointer high", v, 8'h01);
    wrReg(5'h02, 8'hFF); wrReg(5'h03, 8'h03);
    csOn; spiByte(8'h7A, r); spiByte(8'hB1, r); spiByte(8'hB2, r); csOff;
    chk("R7 top address", mem[10'h3FF], 8'hB1);
    chk("R7 wrapped address", mem[0], 8'hB2);
    rdReg(5'h02, 0, v); chk("R7 pointer after wrap", v, 8'h01);

    // R8 buffer read
    wrReg(5'h00, 8'h20); wrReg(5'h01, 8'h01);
    csOn; spiByte(8'h3A, r);
    for (int i = 0; i < 6; i++) begin spiByte(8'h00, v); chk("R8 streamed byte", v, sent[i]); end
    csOff;
    rdReg(5'h00, 0, v); chk("R8 read pointer advanced", v, 8'h26);

    // R10 abort
    wrReg(5'h1F, 8'h00);
    csOn; spiByte(8'h5F, r); spiBits(8'hFF, 4, r); csOff;
    rdReg(5'h1F, 0, v); chk("R10 partial data dropped", v, 8'h00);
    csOn; spiBits(8'hE0, 3, r); csOff;
    rdReg(5'h1B, 0, v); chk("R10 realigned after abort", v, 8'h5A);

    // R1 unknown commands
    we0 = weCount;
    cmd2(8'h7F, 8'h03); cmd2(8'h3F, 8'h03); cmd2(8'hDF, 8'h03); cmd2(8'h66, 8'h55);
    rdReg(5'h1F, 0, v); chk("R1 unknown commands ignored", v, 8'h00);
    chk("R1 no external write", 16'(weCount - we0), 16'd0);
    csOn; spiByte(8'hC5, r); spiByte(8'h00, v); csOff;
    chk("R1 unknown command replies zero", v, 8'h00);

    // R11 soft reset
    setBank(2);
    wrReg(5'h1E, 8'h77);
    csOn; spiByte(8'hFF, r); csOff;
    chk("R11 one pulse", 16'(softCount), 16'd1);
    rdReg(5'h1F, 0, v); chk("R11 bank cleared", v, 8'h00);
    rdReg(5'h1E, 0, v); chk("R11 control 2 cleared", v, 8'h00);
    rdReg(5'h1B, 0, v); chk("R11 enable cleared", v, 8'h00);
    rdReg(5'h02, 0, v); chk("R11 write pointer cleared", v, 8'h00);
    rdReg(5'h00, 0, v); chk("R11 read pointer cleared", v, 8'h00);

    // random banked traffic (R4 R5 R6)
    for (int i = 0; i < 128; i++) expReg[i] = ext[i];
    for (int it = 0; it < 16; it++) begin
      int b, a, idx;
      b = int'($urandom % 4);
      a = int'($urandom % 27);
      if (b == 0 && a < 4) a = a + 4;
      idx = b * 32 + a;
      d = 8'($urandom);
      setBank(b);
      wrReg(5'(a), d); expReg[idx] = d;
      rdReg(5'(a), slowReg(b, a), v); chk("R4 random readback", v, expReg[idx]);
      dm = 8'($urandom);
      if (it % 2 == 0) begin
        cmd2({3'b100, 5'(a)}, dm);
        if (!slowReg(b, a)) expReg[idx] = expReg[idx] | dm;
      end else begin
        cmd2({3'b101, 5'(a)}, dm);
        if (!slowReg(b, a)) expReg[idx] = expReg[idx] & ~dm;
      end
      rdReg(5'(a), slowReg(b, a), v); chk("R6 random mask", v, expReg[idx]);
      chk("R5 random external copy", ext[idx], expReg[idx]);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule